// File: doc/BRIEF.md
# Synchronous Burst Static RAM

A single-port static RAM, 18 bits wide, whose inputs are all taken on the rising clock edge. A full-size build holds 32,768 words and uses `ADDR_W = 15`. The default build keeps `ADDR_W = 11` so that elaboration stays small. The block serves as the data store of a cache. It sends and receives data on one bidirectional bus, and the host sends only the first address of each four-word line.

A transfer begins on one of two start strobes, one from the processor and one from the cache controller. A start loads the word address, and the block then accepts each later beat of the line on its own burst-advance input. The burst steps through the four words of the line in linear order and wraps around inside that line. The address bits above the two lowest stay fixed for the whole line.

Writes complete at the same edge that captures them. The two 9-bit lanes of each word can be written separately. The output enable is not sampled by the clock: it drives the data bus or floats it at once.

Top module: `sync_burst_sram`

## Requirements
- R1: While `rst_n` is low, the output register holds zero, so with `out_en_n` low the bus reads 0.
- R2: On an edge where `sel_n` is low, `cpu_start_n` or `ctl_start_n` low starts a transfer at `addr`. The word at `addr` appears on `dq` after the following edge.
- R3: On an edge where `sel_n` is high, both start strobes are ignored. No address is loaded and no write takes place, and the previously addressed word stays on the output.
- R4: Each edge with `burst_next_n` low and no accepted start moves to word (loaded addr[1:0] + count) mod 4 of the same line. The upper address bits never change during a burst.
- R5: An edge with no accepted start and `burst_next_n` high keeps the current address, and the same word is read again.
- R6: `wr_lo_n` low writes bits 8:0 and `wr_hi_n` low writes bits 17:9, taken from `dq` at the edge. The lane that is not enabled keeps its contents.
- R7: An accepted start with `cpu_start_n` low is a read even when `ctl_start_n` is low too. Both write enables are ignored on that edge.
- R8: Write enables take effect on a controller start edge and on advance edges. They are ignored on hold edges.
- R9: `out_en_n` high floats `dq` and `out_en_n` low drives the output register onto `dq`, both without any clock edge.
- R10: After a write, the edge that follows puts the newly written word on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input except `out_en_n` is taken on its rising edge |
| rst_n | input | 1 | Active-low reset of the address state and the output register |
| sel_n | input | 1 | Active-low chip select; gates the start strobes |
| cpu_start_n | input | 1 | Active-low transfer start from the processor; always a read |
| ctl_start_n | input | 1 | Active-low transfer start from the cache controller |
| burst_next_n | input | 1 | Active-low advance to the next word of the line |
| wr_lo_n | input | 1 | Active-low write enable for bits 8:0 |
| wr_hi_n | input | 1 | Active-low write enable for bits 17:9 |
| out_en_n | input | 1 | Active-low output enable, not clocked |
| addr | input | ADDR_W | Word address, loaded on a start |
| dq | inout | 18 | Shared data-in and data-out bus |

## Verification
Two functions can fall on the same edge: a write to a word, and the output register loading the word that was registered just before. The bench provokes this by following a controller-start write, and an advance write, with a hold edge. It then judges that the output shows the merged word at once, with only the enabled lane new. A second overlap comes from asserting both start strobes together with the write enables. The bench then reads the target back and judges that it is unchanged and that the loaded address is the one driven.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 11,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              cpu_start_n,
  input  logic              ctl_start_n,
  input  logic              burst_next_n,
  input  logic              wr_lo_n,
  input  logic              wr_hi_n,
  input  logic              out_en_n,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [2*LANE_W-1:0] dq
);
  localparam int DW    = 2 * LANE_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int HI_W  = ADDR_W - 2;

  logic [DW-1:0]   mem [DEPTH];
  logic [HI_W-1:0] base;
  logic [1:0]      lo, cnt;
  logic [DW-1:0]   q;

  wire start   = !sel_n && (!cpu_start_n || !ctl_start_n);
  wire rd_only = start && !cpu_start_n;
  wire step    = !start && !burst_next_n;
  wire wr_ok   = (start && !rd_only) || step;
  wire wr_lo   = wr_ok && !wr_lo_n;
  wire wr_hi   = wr_ok && !wr_hi_n;

  wire [1:0]        nxt_cnt  = start ? 2'd0 : (step ? cnt + 2'd1 : cnt);
  wire [HI_W-1:0]   nxt_base = start ? addr[ADDR_W-1:2] : base;
  wire [1:0]        nxt_lo   = start ? addr[1:0] : lo;
  wire [1:0]        nxt_word = nxt_lo + nxt_cnt;
  wire [ADDR_W-1:0] nxt_addr = {nxt_base, nxt_word};
  wire [1:0]        cur_word = lo + cnt;
  wire [ADDR_W-1:0] cur_addr = {base, cur_word};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
      lo   <= '0;
      cnt  <= '0;
    end else begin
      base <= nxt_base;
      lo   <= nxt_lo;
      cnt  <= nxt_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_lo) mem[nxt_addr][LANE_W-1:0]  <= dq[LANE_W-1:0];
    if (wr_hi) mem[nxt_addr][DW-1:LANE_W] <= dq[DW-1:LANE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= mem[cur_addr];
  end

  assign dq = out_en_n ? {DW{1'bz}} : q;

  AST_START_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cnt == 2'd0); // R2
  AST_IGNORED_START: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n && burst_next_n) |=> ($stable(base) && $stable(lo) && $stable(cnt))); // R3
  AST_ADVANCE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt == $past(cnt) + 2'd1); // R4
  AST_LINE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(base) && $stable(lo))); // R4
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && burst_next_n) |=> $stable(cnt)); // R5
  AST_CPU_START_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !cpu_start_n) |-> !(wr_lo || wr_hi)); // R7
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && burst_next_n) |-> !(wr_lo || wr_hi)); // R8
endmodule

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;
  localparam int AW = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b0, cpu_start_n = 1'b1, ctl_start_n = 1'b1, burst_next_n = 1'b1;
  logic wr_lo_n = 1'b1, wr_hi_n = 1'b1, out_en_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic drv = 1'b0;
  logic [17:0] dval = '0;
  wire  [17:0] dq;
  logic [17:0] exp_mem [1 << AW];
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  assign dq = drv ? dval : 18'bz;

  always #4 clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .LANE_W(9)) dut (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .cpu_start_n(cpu_start_n),
    .ctl_start_n(ctl_start_n), .burst_next_n(burst_next_n), .wr_lo_n(wr_lo_n),
    .wr_hi_n(wr_hi_n), .out_en_n(out_en_n), .addr(addr), .dq(dq)
  );

  task automatic check(string req, logic [17:0] got, logic [17:0] expv);
    n_cmp++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, expv);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    sel_n = 1'b0; cpu_start_n = 1'b1; ctl_start_n = 1'b1; burst_next_n = 1'b1;
    wr_lo_n = 1'b1; wr_hi_n = 1'b1; drv = 1'b0; out_en_n = 1'b0;
  endtask

  function automatic logic [AW-1:0] word(logic [AW-1:0] a, int k);
    return {a[AW-1:2], 2'(a[1:0] + k)};
  endfunction

  task automatic wr_burst(logic [AW-1:0] a, logic [17:0] d0, logic [17:0] d1,
                          logic [17:0] d2, logic [17:0] d3);
    logic [17:0] dv [4];
    dv = '{d0, d1, d2, d3};
    out_en_n = 1'b1; drv = 1'b1; wr_lo_n = 1'b0; wr_hi_n = 1'b0; addr = a;
    for (int k = 0; k < 4; k++) begin
      ctl_start_n  = (k == 0) ? 1'b0 : 1'b1;
      burst_next_n = (k == 0) ? 1'b1 : 1'b0;
      dval = dv[k];
      tick();
      exp_mem[word(a, k)] = dv[k];
    end
    idle();
  endtask

  task automatic rd_burst(logic [AW-1:0] a, bit use_cpu, string req);
    idle();
    addr = a;
    if (use_cpu) cpu_start_n = 1'b0; else ctl_start_n = 1'b0;
    tick();
    idle();
    for (int k = 0; k < 4; k++) begin
      burst_next_n = (k < 3) ? 1'b0 : 1'b1;
      tick();
      check(req, dq, exp_mem[word(a, k)]);
    end
    idle();
  endtask

  task automatic t_reset();
    out_en_n = 1'b0;
    tick();
    check("R1 reset output", dq, 18'h0);
    tick();
    check("R1 reset output held", dq, 18'h0);
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_bursts();
    wr_burst(11'h041, 18'h11111, 18'h22222, 18'h33333, 18'h04444);
    rd_burst(11'h042, 1'b1, "R2 R4 cpu start wrap");
    rd_burst(11'h040, 1'b0, "R2 ctl start read");
    wr_burst(11'h7FE, 18'h3A001, 18'h3A002, 18'h3A003, 18'h3A004);
    rd_burst(11'h7FF, 1'b1, "R4 upper bits fixed at top line");
  endtask

  task automatic t_hold();
    idle(); addr = 11'h043; cpu_start_n = 1'b0;
    tick(); idle();
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R5 hold rereads word", dq, exp_mem[11'h043]);
    end
  endtask

  task automatic t_ignore();
    idle(); sel_n = 1'b1; cpu_start_n = 1'b0; addr = 11'h7FC;
    tick(); idle();
    tick();
    check("R3 ignored cpu start", dq, exp_mem[11'h043]);
    idle(); sel_n = 1'b1; ctl_start_n = 1'b0; addr = 11'h040;
    wr_lo_n = 1'b0; wr_hi_n = 1'b0; out_en_n = 1'b1; drv = 1'b1; dval = 18'h15555;
    tick(); idle();
    tick();
    check("R3 ignored ctl start keeps output", dq, exp_mem[11'h043]);
    rd_burst(11'h040, 1'b1, "R3 ignored start wrote nothing");
  endtask

  task automatic t_bytes();
    idle(); ctl_start_n = 1'b0; addr = 11'h041; wr_lo_n = 1'b0;
    out_en_n = 1'b1; drv = 1'b1; dval = 18'h3FFFF;
    tick();
    exp_mem[11'h041][8:0] = 9'h1FF;
    idle();
    tick();
    check("R6 R10 lower lane write seen next edge", dq, exp_mem[11'h041]);
    idle(); ctl_start_n = 1'b0; addr = 11'h042;
    tick();
    idle(); burst_next_n = 1'b0; wr_hi_n = 1'b0; out_en_n = 1'b1; drv = 1'b1;
    dval = 18'h2AAAA;
    tick();
    exp_mem[11'h043][17:9] = 9'h155;
    idle();
    tick();
    check("R6 R10 upper lane write on advance", dq, exp_mem[11'h043]);
  endtask

  task automatic t_cpu_read();
    idle(); cpu_start_n = 1'b0; addr = 11'h040; wr_lo_n = 1'b0; wr_hi_n = 1'b0;
    out_en_n = 1'b1; drv = 1'b1; dval = 18'h12345;
    tick(); idle();
    tick();
    check("R7 cpu start ignores write enables", dq, exp_mem[11'h040]);
    idle(); cpu_start_n = 1'b0; ctl_start_n = 1'b0; addr = 11'h041;
    wr_lo_n = 1'b0; wr_hi_n = 1'b0; out_en_n = 1'b1; drv = 1'b1; dval = 18'h0BEEF;
    tick(); idle();
    tick();
    check("R7 both strobes act as read", dq, exp_mem[11'h041]);
  endtask

  task automatic t_hold_nowrite();
    idle(); wr_lo_n = 1'b0; wr_hi_n = 1'b0; out_en_n = 1'b1; drv = 1'b1;
    dval = 18'h00F0F;
    tick(); idle();
    tick();
    check("R8 hold edge ignores write enables", dq, exp_mem[11'h041]);
  endtask

  task automatic t_oe();
    out_en_n = 1'b1;
    #1;
    check("R9 bus floats when disabled", dq, 18'bz);
    out_en_n = 1'b0;
    #1;
    check("R9 bus driven without clock", dq, exp_mem[11'h041]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    #2;
    t_reset();
    t_bursts();
    t_hold();
    t_ignore();
    t_bytes();
    t_cpu_read();
    t_hold_nowrite();
    t_oe();
    finish_run();
  end
endmodule